// File: doc/BRIEF.md
# Fat-Tree Switch Fault Rerouting Decision Logic

This block makes the per-packet output-port decision for one switch in a fat tree whose switches have 2K ports. Each cycle it takes a packet header (destination leaf address, travel phase, escape flag), the switch's tier and subtree prefix, and a per-port fault mask. One cycle later it returns the chosen output port, the updated phase and escape flag, or a drop indication. The switch keeps no routing state. Output depends only on the current inputs, so clearing a fault bit restores the deterministic route on the very next packet, with no reconfiguration.

Ports 0..K-1 face down and ports K..2K-1 face up. K must be a power of two. The leaf address is N_TIERS base-K digits; digit j occupies bits [j*DW +: DW] with DW = log2(K). The digit selected by the switch's tier, d = digit[tier], picks the preferred downward port d and the preferred upward port K+d. A switch at tier t covers a destination when every digit j > t of the destination equals the same digit of sw_prefix. The top tier (N_TIERS-1) covers everything and has no usable upward ports. Tier 0 is leaf level.

When a preferred link is faulty, the switch escapes locally. For an upward move it takes another healthy upward port. For a downward move it takes another healthy child and sets the escape flag. A packet travelling down through switches that do not cover its destination keeps descending to leaf level and then turns back upward (a U-turn). This way a detour started at tier 2 or higher passes two tiers below the faulty point before it climbs again.

Top module: `ftree_reroute`

## Requirements
- R1: During reset and on the cycle after it, out_valid and out_drop are 0. Otherwise out_valid equals in_valid of the previous cycle, and all decisions appear one cycle after their inputs.
- R2: An upward-phase packet (in_phase=0) at a non-covering switch, with a healthy preferred upward port, leaves on port K+d with phase 0 and its escape flag unchanged.
- R3: A packet at a covering switch whose preferred downward port d is healthy leaves on port d with phase 1 (down) and escape flag 0.
- R4: When the preferred upward port is faulty, the packet takes upward port K+((d+i) mod K) for the smallest i with a healthy port. With at most K-1 faulty upward ports, it is never dropped or sent down. No chosen port is ever faulty.
- R5: At a covering switch above tier 0 whose preferred downward port is faulty, the packet takes downward port (d+i) mod K for the smallest healthy i, with phase 1 and escape flag 1.
- R6: A downward-phase packet at a non-covering tier-0 switch makes a U-turn. It leaves on upward port K+((d+i) mod K) for the smallest healthy i, with phase 0 and escape flag 1.
- R7: A downward-phase packet at a non-covering switch above tier 0 keeps descending on downward port (d+i) mod K for the smallest healthy i, with escape flag 1.
- R8: If an upward move finds every upward port faulty, the packet detours downward (smallest healthy i from d, escape 1). If a covering switch above tier 0 finds every downward port faulty, the packet goes up (smallest healthy i from d, phase 0, escape 1).
- R9: When no legal port exists, out_drop is 1 and out_port is 0. A covering tier-0 switch whose preferred port d is faulty drops the packet.
- R10: At the top tier, the upward fault-mask bits have no effect and no upward port is ever chosen.
- R11: With an all-zero fault mask the block never drops. Once the mask clears, the same header gets the deterministic R2/R3 port again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header present this cycle |
| in_dst | input | N_TIERS*DW | Destination leaf address, base-K digits |
| in_phase | input | 1 | 0 = travelling up, 1 = travelling down |
| in_escape | input | 1 | Escape flag carried in the header |
| sw_tier | input | TW | Tier of this switch, 0 = leaf level |
| sw_prefix | input | N_TIERS*DW | Address digits of this switch's subtree |
| fault_mask | input | 2*K | 1 marks a faulty port |
| out_valid | output | 1 | Decision present |
| out_port | output | PW | Chosen output port |
| out_phase | output | 1 | Updated phase |
| out_escape | output | 1 | Updated escape flag |
| out_drop | output | 1 | No legal port, packet dropped |

## Verification
The checker watches every cycle for the following:
- a chosen port whose mask bit was set in the decision cycle,
- an upward port chosen at the top tier,
- a drop under a clean mask,
- an output phase that disagrees with the side of the chosen port,
- the reset and valid timing.

Which port is chosen in each escape case can only be shown by the bench. This covers the cyclic search order, the U-turn at leaf level, the continued descent above it, and the escape-flag updates. The bench compares every decision against a model of the requirements, over directed corner cases and a seeded random sweep of headers, tiers and masks.

// File: rtl/ftr_pkg.sv
package ftr_pkg;

    // Travel direction carried in the packet header
    typedef enum logic {
        PH_UP   = 1'b0,
        PH_DOWN = 1'b1
    } phase_e;

    // Outcome of the per-packet decision
    typedef enum logic [1:0] {
        ACT_UP   = 2'd0,
        ACT_DOWN = 2'd1,
        ACT_DROP = 2'd2
    } act_e;

    // Header flags after the decision
    typedef struct packed {
        phase_e phase;
        logic   escape;
    } flags_t;

    // Bit width for an index over n items, never below one
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fr_pick.sv
// Cyclic search: first healthy index at or after 'start', wrapping modulo N.
// N must be a power of two so that the index sum wraps naturally.
module fr_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0]                        healthy,
    input  logic [ftr_pkg::idx_width(N)-1:0]    start,
    output logic                                found,
    output logic [ftr_pkg::idx_width(N)-1:0]    idx
);
    localparam int SW = ftr_pkg::idx_width(N);

    logic [2*N-1:0] doubled;
    logic [N-1:0]   rotated;
    logic [SW-1:0]  offset;

    assign doubled = {healthy, healthy} >> start;
    assign rotated = doubled[N-1:0];
    assign found   = |rotated;

    always_comb begin
        offset = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (rotated[i]) offset = SW'(i);
        end
    end

    assign idx = start + offset;

endmodule

// File: rtl/fr_cover.sv
// Subtree membership: a switch at tier t covers a destination whose digits
// above t match its prefix; the top tier covers every destination.
module fr_cover #(
    parameter int K       = 4,
    parameter int N_TIERS = 3
) (
    input  logic [N_TIERS*ftr_pkg::idx_width(K)-1:0] dst,
    input  logic [N_TIERS*ftr_pkg::idx_width(K)-1:0] prefix,
    input  logic [ftr_pkg::idx_width(N_TIERS)-1:0]   tier,
    output logic                                     covers
);
    localparam int DW = ftr_pkg::idx_width(K);

    logic [N_TIERS-1:0] digit_eq;

    for (genvar j = 0; j < N_TIERS; j++) begin : g_digit
        assign digit_eq[j] = (dst[j*DW +: DW] == prefix[j*DW +: DW]);
    end

    always_comb begin
        covers = 1'b1;
        for (int j = 0; j < N_TIERS; j++) begin
            if (j > int'(tier) && !digit_eq[j]) covers = 1'b0;
        end
    end

endmodule

// File: rtl/fr_decide.sv
// Combinational port choice with local escape rules.
module fr_decide
    import ftr_pkg::*;
#(
    parameter int K       = 4,
    parameter int N_TIERS = 3
) (
    input  logic [N_TIERS*idx_width(K)-1:0] dst,
    input  logic [N_TIERS*idx_width(K)-1:0] prefix,
    input  logic [idx_width(N_TIERS)-1:0]   tier,
    input  phase_e                          phase_in,
    input  logic                            esc_in,
    input  logic [2*K-1:0]                  fault_mask,
    output act_e                            act,
    output logic [idx_width(2*K)-1:0]       port,
    output flags_t                          flags
);
    localparam int DW  = idx_width(K);
    localparam int TW  = idx_width(N_TIERS);
    localparam int PW  = idx_width(2 * K);
    localparam int TOP = N_TIERS - 1;

    logic [DW-1:0] dig;
    logic          is_top, is_leaf, covers;
    logic [K-1:0]  dn_healthy, up_healthy;
    logic          dn_found, up_found;
    logic [DW-1:0] dn_idx, up_idx;

    assign dig        = dst[int'(tier)*DW +: DW];
    assign is_top     = (tier == TW'(TOP));
    assign is_leaf    = (tier == '0);
    assign dn_healthy = ~fault_mask[K-1:0];
    // the top tier has no parents: its upward mask bits are meaningless
    assign up_healthy = ~fault_mask[2*K-1:K] & {K{~is_top}};

    fr_cover #(.K(K), .N_TIERS(N_TIERS)) i_cover (
        .dst    (dst),
        .prefix (prefix),
        .tier   (tier),
        .covers (covers)
    );

    fr_pick #(.N(K)) i_pick_dn (
        .healthy (dn_healthy),
        .start   (dig),
        .found   (dn_found),
        .idx     (dn_idx)
    );

    fr_pick #(.N(K)) i_pick_up (
        .healthy (up_healthy),
        .start   (dig),
        .found   (up_found),
        .idx     (up_idx)
    );

    logic esc_next;

    always_comb begin
        act      = ACT_DROP;
        esc_next = esc_in;
        if (covers) begin
            if (dn_healthy[dig]) begin
                act      = ACT_DOWN;          // turning down on the direct path
                esc_next = 1'b0;
            end else if (is_leaf) begin
                act      = ACT_DROP;          // only link to the leaf is dead
            end else if (dn_found) begin
                act      = ACT_DOWN;          // sideways child, will U-turn below
                esc_next = 1'b1;
            end else if (up_found) begin
                act      = ACT_UP;            // retreat upward
                esc_next = 1'b1;
            end
        end else if (phase_in == PH_UP) begin
            if (up_found) begin
                act      = ACT_UP;            // every parent reaches a root
            end else if (dn_found) begin
                act      = ACT_DOWN;          // detour down, U-turn later
                esc_next = 1'b1;
            end
        end else begin
            if (is_leaf) begin
                if (up_found) begin
                    act      = ACT_UP;        // U-turn at leaf level
                    esc_next = 1'b1;
                end
            end else if (dn_found) begin
                act      = ACT_DOWN;          // keep descending on the detour
                esc_next = 1'b1;
            end else if (up_found) begin
                act      = ACT_UP;
                esc_next = 1'b1;
            end
        end
    end

    always_comb begin
        unique case (act)
            ACT_UP: begin
                port         = PW'(K) + PW'(up_idx);
                flags.phase  = PH_UP;
                flags.escape = esc_next;
            end
            ACT_DOWN: begin
                port         = PW'(dn_idx);
                flags.phase  = PH_DOWN;
                flags.escape = esc_next;
            end
            default: begin
                port         = '0;
                flags.phase  = phase_in;
                flags.escape = esc_in;
            end
        endcase
    end

endmodule

// File: rtl/ftree_reroute.sv
// Fat-tree switch output-port decision with local fault escape, one-cycle latency.
module ftree_reroute
    import ftr_pkg::*;
#(
    parameter int K       = 4,
    parameter int N_TIERS = 3
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  in_valid,
    input  logic [N_TIERS*idx_width(K)-1:0]       in_dst,
    input  logic                                  in_phase,
    input  logic                                  in_escape,
    input  logic [idx_width(N_TIERS)-1:0]         sw_tier,
    input  logic [N_TIERS*idx_width(K)-1:0]       sw_prefix,
    input  logic [2*K-1:0]                        fault_mask,
    output logic                                  out_valid,
    output logic [idx_width(2*K)-1:0]             out_port,
    output logic                                  out_phase,
    output logic                                  out_escape,
    output logic                                  out_drop
);
    localparam int PW = idx_width(2 * K);

    act_e          act;
    logic [PW-1:0] port_c;
    flags_t        flags_c;

    fr_decide #(.K(K), .N_TIERS(N_TIERS)) i_decide (
        .dst        (in_dst),
        .prefix     (sw_prefix),
        .tier       (sw_tier),
        .phase_in   (phase_e'(in_phase)),
        .esc_in     (in_escape),
        .fault_mask (fault_mask),
        .act        (act),
        .port       (port_c),
        .flags      (flags_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_port   <= '0;
            out_phase  <= 1'b0;
            out_escape <= 1'b0;
            out_drop   <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            out_port   <= in_valid ? port_c : '0;
            out_phase  <= in_valid & flags_c.phase;
            out_escape <= in_valid & flags_c.escape;
            out_drop   <= in_valid & (act == ACT_DROP);
        end
    end

endmodule

// File: rtl/fr_check.sv
module fr_check
    import ftr_pkg::*;
#(
    parameter int K       = 4,
    parameter int N_TIERS = 3
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            in_valid,
    input logic [N_TIERS*idx_width(K)-1:0] in_dst,
    input logic                            in_phase,
    input logic                            in_escape,
    input logic [idx_width(N_TIERS)-1:0]   sw_tier,
    input logic [N_TIERS*idx_width(K)-1:0] sw_prefix,
    input logic [2*K-1:0]                  fault_mask,
    input logic                            out_valid,
    input logic [idx_width(2*K)-1:0]       out_port,
    input logic                            out_phase,
    input logic                            out_escape,
    input logic                            out_drop
);
    localparam int TW  = idx_width(N_TIERS);
    localparam int TOP = N_TIERS - 1;

    logic           valid_q;
    logic [2*K-1:0] mask_q;
    logic [TW-1:0]  tier_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            mask_q  <= '0;
            tier_q  <= '0;
        end else begin
            valid_q <= in_valid;
            mask_q  <= fault_mask;
            tier_q  <= sw_tier;
        end
    end

    // R1: reset clears the outputs
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_drop));

    // R1: one-cycle valid latency
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid == valid_q);

    // R4: a chosen port is never one marked faulty
    p_never_faulty_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_drop) |-> !mask_q[out_port]);

    // R10: top tier never climbs
    p_top_no_up_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_drop && tier_q == TW'(TOP)) |-> (int'(out_port) < K));

    // R11: a clean mask never drops
    p_clean_no_drop_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mask_q == '0) |-> !out_drop);

    // R3: phase agrees with the side of the chosen port
    p_phase_side_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_drop) |-> (out_phase == (int'(out_port) < K)));

    // R9: a drop carries port 0 and a valid decision
    p_drop_port_r9: assert property (@(posedge clk) disable iff (rst)
        out_drop |-> (out_valid && out_port == '0));

endmodule

bind ftree_reroute fr_check #(.K(K), .N_TIERS(N_TIERS)) i_fr_check (.*);

// File: tb/test_ftree_reroute.sv
`timescale 1ns/1ps
module test_ftree_reroute;
    localparam int K   = 4;
    localparam int NT  = 3;
    localparam int DW  = 2;
    localparam int AW  = NT * DW;
    localparam int TW  = 2;
    localparam int PW  = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid, in_phase, in_escape;
    logic [AW-1:0] in_dst, sw_prefix;
    logic [TW-1:0] sw_tier;
    logic [2*K-1:0] fault_mask;
    logic          out_valid, out_phase, out_escape, out_drop;
    logic [PW-1:0] out_port;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ftree_reroute #(.K(K), .N_TIERS(NT)) i_ftree_reroute (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dst(in_dst),
        .in_phase(in_phase), .in_escape(in_escape), .sw_tier(sw_tier),
        .sw_prefix(sw_prefix), .fault_mask(fault_mask), .out_valid(out_valid),
        .out_port(out_port), .out_phase(out_phase), .out_escape(out_escape),
        .out_drop(out_drop)
    );

    // first healthy (d+i) mod K in a K-bit health vector, -1 if none
    function automatic int scan(input logic [K-1:0] h, input int d);
        for (int i = 0; i < K; i++)
            if (h[(d + i) % K]) return (d + i) % K;
        return -1;
    endfunction

    // expected {drop, port, phase, escape} from the requirements
    function automatic logic [PW+2:0] model(input logic [AW-1:0] dst, input logic ph,
            input logic esc, input int tier, input logic [AW-1:0] pre, input logic [2*K-1:0] m);
        int d, dn, up;
        bit cov, top, leaf;
        logic [K-1:0] dh, uh;
        d = int'(dst >> (tier * DW)) % K;
        top = (tier == NT - 1);
        leaf = (tier == 0);
        cov = 1;
        for (int j = tier + 1; j < NT; j++)
            if (((dst >> (j*DW)) & 3) != ((pre >> (j*DW)) & 3)) cov = 0;
        dh = ~m[K-1:0];
        uh = top ? '0 : ~m[2*K-1:K];
        dn = scan(dh, d);
        up = scan(uh, d);
        if (cov) begin
            if (dh[d])            return {1'b0, PW'(d), 1'b1, 1'b0};
            else if (leaf)        return {1'b1, PW'(0), ph, esc};
            else if (dn >= 0)     return {1'b0, PW'(dn), 1'b1, 1'b1};
            else if (up >= 0)     return {1'b0, PW'(K + up), 1'b0, 1'b1};
        end else if (!ph) begin
            if (up >= 0)          return {1'b0, PW'(K + up), 1'b0, esc};
            else if (dn >= 0)     return {1'b0, PW'(dn), 1'b1, 1'b1};
        end else if (leaf) begin
            if (up >= 0)          return {1'b0, PW'(K + up), 1'b0, 1'b1};
        end else begin
            if (dn >= 0)          return {1'b0, PW'(dn), 1'b1, 1'b1};
            else if (up >= 0)     return {1'b0, PW'(K + up), 1'b0, 1'b1};
        end
        return {1'b1, PW'(0), ph, esc};
    endfunction

    task automatic chk(input string tag, input logic [PW+3:0] got, input logic [PW+3:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got {valid,drop,port,phase,esc}=%b expected %b", tag, got, exp);
        end
    endtask

    // drive at a falling edge, compare at the next falling edge
    task automatic run(input string tag, input logic [AW-1:0] dst, input logic ph,
            input logic esc, input int tier, input logic [AW-1:0] pre, input logic [2*K-1:0] m);
        in_valid = 1'b1; in_dst = dst; in_phase = ph; in_escape = esc;
        sw_tier = TW'(tier); sw_prefix = pre; fault_mask = m;
        @(negedge clk);
        chk(tag, {out_valid, out_drop, out_port, out_phase, out_escape},
            {1'b1, model(dst, ph, esc, tier, pre, m)});
    endtask

    task automatic expect_port(input string tag, input int port, input logic drop);
        checks++;
        if (out_drop !== drop || (!drop && int'(out_port) != port)) begin
            failures++;
            $display("FAIL %s: got port=%0d drop=%b expected port=%0d drop=%b",
                     tag, out_port, out_drop, port, drop);
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                failures++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_dst = '0; in_phase = 1'b0; in_escape = 1'b0;
        sw_tier = '0; sw_prefix = '0; fault_mask = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset", {out_valid, out_drop, out_port, out_phase, out_escape}, '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle", {out_valid, out_drop, out_port, out_phase, out_escape}, '0);

        // dst digits: d2=2 d1=1 d0=3 -> 6'b10_01_11 ; prefix d2=0 so tier1 not covering
        // R2: fault-free climb at tier1, digit1=1 -> port 5
        run("R2 up", 6'b100111, 1'b0, 1'b0, 1, 6'b000000, '0);
        expect_port("R2 up port", 5, 1'b0);
        // R3: top tier, digit2=2 -> down port 2, escape cleared
        run("R3 down", 6'b100111, 1'b1, 1'b1, 2, 6'b000000, '0);
        expect_port("R3 down port", 2, 1'b0);
        // R4: up port 5 faulty -> 6; ports 5,6 faulty -> 7; 5,6,7 faulty -> 4
        run("R4 alt up", 6'b100111, 1'b0, 1'b0, 1, 6'b000000, 8'b0010_0000);
        expect_port("R4 alt up port", 6, 1'b0);
        run("R4 wrap up", 6'b100111, 1'b0, 1'b0, 1, 6'b000000, 8'b1110_0000);
        expect_port("R4 wrap up port", 4, 1'b0);
        // R5: tier1 covering (prefix d2=2), down port 1 faulty -> 2, escape 1
        run("R5 alt down", 6'b100111, 1'b0, 1'b0, 1, 6'b100000, 8'b0000_0010);
        expect_port("R5 alt down port", 2, 1'b0);
        // R6: leaf tier, down phase, not covering -> U-turn, digit0=3 -> port 7
        run("R6 uturn", 6'b100111, 1'b1, 1'b1, 0, 6'b000000, '0);
        expect_port("R6 uturn port", 7, 1'b0);
        // R7: tier1 down phase not covering -> keep descending, port 1 faulty -> 2
        run("R7 descend", 6'b100111, 1'b1, 1'b1, 1, 6'b000000, 8'b0000_0010);
        expect_port("R7 descend port", 2, 1'b0);
        // R8: all up faulty on climb -> down detour from digit 1
        run("R8 down detour", 6'b100111, 1'b0, 1'b0, 1, 6'b000000, 8'b1111_0000);
        expect_port("R8 down detour port", 1, 1'b0);
        run("R8 up retreat", 6'b100111, 1'b1, 1'b0, 1, 6'b100000, 8'b0000_1111);
        expect_port("R8 up retreat port", 5, 1'b0);
        // R9: nothing healthy -> drop; dead leaf link at covering leaf switch -> drop
        run("R9 all dead", 6'b100111, 1'b0, 1'b0, 1, 6'b000000, 8'hFF);
        expect_port("R9 all dead", 0, 1'b1);
        run("R9 leaf link", 6'b100111, 1'b1, 1'b0, 0, 6'b100100, 8'b0000_1000);
        expect_port("R9 leaf link", 0, 1'b1);
        // R10: top tier, all down dead, up bits clear -> drop, never climb
        run("R10 top", 6'b100111, 1'b1, 1'b0, 2, 6'b000000, 8'b0000_1111);
        expect_port("R10 top", 0, 1'b1);
        run("R10 top mask", 6'b100111, 1'b0, 1'b0, 2, 6'b000000, 8'b1111_0000);
        expect_port("R10 top mask port", 2, 1'b0);
        // R11: mask cleared -> deterministic again
        run("R11 restore", 6'b100111, 1'b0, 1'b0, 1, 6'b000000, '0);
        expect_port("R11 restore port", 5, 1'b0);

        // R1: idle input gives no valid
        in_valid = 1'b0;
        @(negedge clk);
        chk("R1 valid drop", {out_valid, out_drop}, 2'b00);

        void'($urandom(32'd2718));
        for (int n = 0; n < 3000; n++) begin
            logic [2*K-1:0] m;
            int r;
            r = int'($urandom % 4);
            if (r == 0)      m = '0;
            else if (r == 1) m = 8'(1) << ($urandom % 8);
            else             m = 8'($urandom & $urandom);
            run("R11 random", AW'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom % NT), AW'($urandom), m);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule